// File: doc/BRIEF.md
# Flag-Setting Integer Execution Unit

A 32-bit single-cycle integer unit that performs add, subtract, reverse subtract, compare, the bitwise operations OR, AND, XOR and NOT, three kinds of shift, and a move-high add. The second operand comes from a register, from a 5-bit immediate or from a 16-bit immediate. How an immediate is widened depends on the operation.

The result and its write-enable are combinational from the applied operation. The condition flags Z, S, CY and OV are held in a register inside the block. That register is loaded on the rising clock edge when an operation is presented, and each operation class updates the flags by its own rule. A decoder upstream supplies the operation code, the operand form and the register values. A register file downstream takes `result` whenever `result_we` is high.

Top module: `flag_alu`

## Requirements
- R1: ADD (code 0) returns reg2 + operand. CY (flags bit 2) is the unsigned carry out. OV (flags bit 3) is set when both inputs share a sign and the result's sign differs from it.
- R2: SUB (code 1) returns reg2 - operand. SUBR (code 2) returns operand - reg2. CY is set when the minuend is below the subtrahend as unsigned values. OV is set when the input signs differ and the result's sign differs from the minuend's sign.
- R3: CMP (code 3) sets flags exactly as SUB would, and keeps `result_we` low.
- R4: Operand form 0 takes reg1. Form 1 takes imm[4:0]: sign-extended, except zero-extended as a shift count. Form 2 takes imm[15:0]: zero-extended for OR/AND/XOR/NOT (codes 4..7) and sign-extended otherwise.
- R5: OR, AND, XOR and NOT (codes 4, 5, 6, 7) set Z and S from the result, clear OV and leave CY unchanged. NOT returns the inverse of the operand.
- R6: AND with form 2 clears S (flags bit 1) whatever the result.
- R7: SHL, SHR and SAR (codes 8, 9, 10) shift reg2 by the low 5 bits of the operand and clear OV. CY is bit (n-1) of the source for right shifts and bit (32-n) for left shifts. SAR fills with the sign bit.
- R8: A shift amount of zero returns reg2 unchanged and clears CY.
- R9: MOVHI (code 11) returns reg2 + (imm << 16), asserts `result_we` and leaves all flags unchanged.
- R10: For every flag-setting operation, Z (flags bit 0) is 1 exactly when the 32-bit result is zero, and S is result bit 31 (except as in R6).
- R11: With `op_valid` low, or with an unused code (12..15), `result_we` is low and the flags are held.
- R12: Reset (`rst_n` low) clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (R1..R11) |
| src_form | input | 2 | Operand form: 0 reg1, 1 short immediate, 2 long immediate |
| reg1_val | input | 32 | First register operand |
| reg2_val | input | 32 | Second register operand, shift source, minuend of SUB |
| imm_val | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result is to be written back |
| flags | output | 4 | {OV, CY, S, Z} |

## Verification
`result` and `result_we` belong to the operation applied in the same cycle. The flags that operation produces appear only after the next rising edge. The driver changes inputs on the falling edge and queues one expected item per cycle. The monitor pops that item 1 ns after the following rising edge, when the inputs still hold the same operation. So the combinational result and the freshly loaded flags are compared at one sample point, and each belongs to the right operation.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_SUBR  = 4'd2,
      OP_CMP   = 4'd3,
      OP_OR    = 4'd4,
      OP_AND   = 4'd5,
      OP_XOR   = 4'd6,
      OP_NOT   = 4'd7,
      OP_SHL   = 4'd8,
      OP_SHR   = 4'd9,
      OP_SAR   = 4'd10,
      OP_MOVHI = 4'd11
   } alu_op_e;

   typedef enum logic [1:0] {
      FORM_REG   = 2'd0,
      FORM_SHORT = 2'd1,
      FORM_LONG  = 2'd2
   } src_form_e;

   // flag vector positions
   localparam int FL_Z  = 0;
   localparam int FL_S  = 1;
   localparam int FL_CY = 2;
   localparam int FL_OV = 3;

endpackage

// File: rtl/flag_alu_opnd.sv
module flag_alu_opnd #(
   parameter int W  = 32,
   parameter int IS = 5,
   parameter int IL = 16
) (
   input  logic [W-1:0]  reg1_val,
   input  logic [IL-1:0] imm_val,
   input  logic [1:0]    form,
   input  logic          short_zext,
   input  logic          long_zext,
   output logic [W-1:0]  opnd
);
   logic s_ext;
   logic l_ext;

   assign s_ext = imm_val[IS-1] & ~short_zext;
   assign l_ext = imm_val[IL-1] & ~long_zext;

   always_comb begin
      case (form)
         2'd1:    opnd = {{(W-IS){s_ext}}, imm_val[IS-1:0]};
         2'd2:    opnd = {{(W-IL){l_ext}}, imm_val};
         default: opnd = reg1_val;
      endcase
   end
endmodule

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
   parameter int W = 32
) (
   input  logic [W-1:0] x_in,
   input  logic [W-1:0] y_in,
   input  logic         subtract,
   output logic [W-1:0] sum,
   output logic         cy,
   output logic         ov
);
   logic [W-1:0] y_eff;
   logic         c_out;

   assign y_eff        = subtract ? ~y_in : y_in;
   assign {c_out, sum} = {1'b0, x_in} + {1'b0, y_eff} + {{W{1'b0}}, subtract};
   assign cy           = subtract ? ~c_out : c_out;
   assign ov           = (x_in[W-1] == y_eff[W-1]) && (sum[W-1] != x_in[W-1]);
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
   parameter int W   = 32,
   parameter int SHW = 5
) (
   input  logic [W-1:0]   src,
   input  logic [SHW-1:0] amt,
   input  logic           to_left,
   input  logic           arith,
   output logic [W-1:0]   shifted,
   output logic           carry
);
   logic [W-1:0]   lft [0:SHW];
   logic [W-1:0]   rgt [0:SHW];
   logic           fill;
   logic [SHW-1:0] lidx;
   logic [SHW-1:0] ridx;

   assign fill   = arith & src[W-1];
   assign lft[0] = src;
   assign rgt[0] = src;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int D = 1 << k;
      assign lft[k+1] = amt[k] ? {lft[k][W-1-D:0], {D{1'b0}}} : lft[k];
      assign rgt[k+1] = amt[k] ? {{D{fill}}, rgt[k][W-1:D]}   : rgt[k];
   end

   // W - n and n - 1, both modulo W
   assign lidx    = ~amt + SHW'(1);
   assign ridx    = amt - SHW'(1);
   assign shifted = to_left ? lft[SHW] : rgt[SHW];
   assign carry   = (amt == '0) ? 1'b0 : (to_left ? src[lidx] : src[ridx]);
endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_S = 5,
   parameter int IMM_L = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic [1:0]       src_form,
   input  logic [WIDTH-1:0] reg1_val,
   input  logic [WIDTH-1:0] reg2_val,
   input  logic [IMM_L-1:0] imm_val,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic [3:0]       flags
);
   localparam int SHW = $clog2(WIDTH);

   if (WIDTH != (1 << SHW)) begin : g_chk_pow2
      $error("WIDTH must be a power of two");
   end
   if (WIDTH < 2 * IMM_L) begin : g_chk_long
      $error("WIDTH must hold the long immediate shifted up");
   end
   if (IMM_S > IMM_L || IMM_S < 1) begin : g_chk_short
      $error("IMM_S must lie in 1..IMM_L");
   end

   alu_op_e          op;
   logic             is_logic, is_shift, is_arith, known;
   logic [WIDTH-1:0] opnd, a_sum, sh_out, movhi_val;
   logic             a_cy, a_ov, sh_cy;
   logic [WIDTH-1:0] x_sel, y_sel;
   logic [3:0]       fl_next;
   logic             fl_load;

   assign op       = alu_op_e'(op_code);
   assign is_logic = op inside {OP_OR, OP_AND, OP_XOR, OP_NOT};
   assign is_shift = op inside {OP_SHL, OP_SHR, OP_SAR};
   assign is_arith = op inside {OP_ADD, OP_SUB, OP_SUBR, OP_CMP};
   assign known    = is_logic || is_shift || is_arith || (op == OP_MOVHI);

   flag_alu_opnd #(.W(WIDTH), .IS(IMM_S), .IL(IMM_L)) u_opnd (
      .reg1_val  (reg1_val),
      .imm_val   (imm_val),
      .form      (src_form),
      .short_zext(is_shift),
      .long_zext (is_logic),
      .opnd      (opnd)
   );

   assign x_sel = (op == OP_SUBR) ? opnd : reg2_val;
   assign y_sel = (op == OP_SUBR) ? reg2_val : opnd;

   flag_alu_arith #(.W(WIDTH)) u_arith (
      .x_in    (x_sel),
      .y_in    (y_sel),
      .subtract(op != OP_ADD),
      .sum     (a_sum),
      .cy      (a_cy),
      .ov      (a_ov)
   );

   flag_alu_shift #(.W(WIDTH), .SHW(SHW)) u_shift (
      .src    (reg2_val),
      .amt    (opnd[SHW-1:0]),
      .to_left(op == OP_SHL),
      .arith  (op == OP_SAR),
      .shifted(sh_out),
      .carry  (sh_cy)
   );

   assign movhi_val = reg2_val + (WIDTH'(imm_val) << IMM_L);

   always_comb begin
      result  = a_sum;
      fl_next = flags;
      fl_load = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_SUBR, OP_CMP: begin
            fl_load        = 1'b1;
            fl_next[FL_CY] = a_cy;
            fl_next[FL_OV] = a_ov;
         end
         OP_OR, OP_AND, OP_XOR, OP_NOT: begin
            fl_load = 1'b1;
            case (op)
               OP_OR:   result = reg2_val | opnd;
               OP_AND:  result = reg2_val & opnd;
               OP_XOR:  result = reg2_val ^ opnd;
               default: result = ~opnd;
            endcase
            fl_next[FL_OV] = 1'b0;
         end
         OP_SHL, OP_SHR, OP_SAR: begin
            fl_load        = 1'b1;
            result         = sh_out;
            fl_next[FL_CY] = sh_cy;
            fl_next[FL_OV] = 1'b0;
         end
         OP_MOVHI: result = movhi_val;
         default:  result = a_sum;
      endcase
      if (fl_load) begin
         fl_next[FL_Z] = (result == '0);
         fl_next[FL_S] = result[WIDTH-1] &
                         ~((op == OP_AND) && (src_form == FORM_LONG));
      end
   end

   assign result_we = op_valid && known && (op != OP_CMP);

   always_ff @(posedge clk) begin
      if (!rst_n)                  flags <= '0;
      else if (op_valid && fl_load) flags <= fl_next;
   end

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flags));
   // R9
   movhi_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd11) |=> $stable(flags));
   // R5
   logic_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code inside {4'd4, 4'd5, 4'd6, 4'd7}) |=>
      (!flags[FL_OV] && flags[FL_CY] == $past(flags[FL_CY])));
   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code <= 4'd10) |=> (flags[FL_Z] == ($past(result) == '0)));
   // R7
   shift_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code inside {4'd8, 4'd9, 4'd10}) |=> !flags[FL_OV]);
endmodule

// File: tb/sim_flag_alu.sv
`timescale 1ns/100ps
module sim_flag_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [1:0]  src_form = '0;
   logic [31:0] reg1_val = '0, reg2_val = '0;
   logic [15:0] imm_val = '0;
   logic [31:0] result;
   logic        result_we;
   logic [3:0]  flags;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] res;
      logic        we;
      logic [3:0]  fl;
      string       tag;
   } exp_t;
   exp_t q[$];
   logic [3:0] mfl = '0;

   always #2.5 clk = ~clk;

   flag_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .src_form(src_form), .reg1_val(reg1_val), .reg2_val(reg2_val),
      .imm_val(imm_val), .result(result), .result_we(result_we), .flags(flags)
   );

   function automatic exp_t model(logic vld, logic [3:0] op, logic [1:0] fm,
                                  logic [31:0] ra, logic [31:0] rb,
                                  logic [15:0] im, logic [3:0] fl, string tag);
      exp_t e;
      logic [31:0] b, r;
      logic [32:0] w;
      longint sr;
      bit lg, sh, setf, cy, ov;
      int n;
      lg = op inside {4, 5, 6, 7};
      sh = op inside {8, 9, 10};
      case (fm)
         2'd1:    b = sh ? {27'b0, im[4:0]} : {{27{im[4]}}, im[4:0]};
         2'd2:    b = lg ? {16'b0, im} : {{16{im[15]}}, im};
         default: b = ra;
      endcase
      e.tag = tag; e.fl = fl; e.we = vld && op <= 11 && op != 3;
      r = '0; cy = fl[2]; ov = 1'b0; setf = vld && op <= 10;
      n = int'(b[4:0]);
      case (op)
         0: begin
            w = {1'b0, rb} + {1'b0, b}; r = w[31:0]; cy = w[32];
            sr = longint'($signed(rb)) + longint'($signed(b));
         end
         1, 3: begin
            r = rb - b; cy = rb < b;
            sr = longint'($signed(rb)) - longint'($signed(b));
         end
         2: begin
            r = b - rb; cy = b < rb;
            sr = longint'($signed(b)) - longint'($signed(rb));
         end
         4: r = rb | b;
         5: r = rb & b;
         6: r = rb ^ b;
         7: r = ~b;
         8:  begin r = rb << n; cy = (n == 0) ? 1'b0 : rb[32-n]; end
         9:  begin r = rb >> n; cy = (n == 0) ? 1'b0 : rb[n-1]; end
         10: begin r = $signed(rb) >>> n; cy = (n == 0) ? 1'b0 : rb[n-1]; end
         11: r = rb + {im, 16'b0};
         default: r = '0;
      endcase
      if (op <= 3) ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      e.res = r;
      if (setf) begin
         e.fl[0] = (r == 0);
         e.fl[1] = r[31] && !(op == 5 && fm == 2);
         e.fl[2] = cy;
         e.fl[3] = ov;
      end
      return e;
   endfunction

   task automatic send(logic vld, logic [3:0] op, logic [1:0] fm,
                       logic [31:0] ra, logic [31:0] rb, logic [15:0] im,
                       string tag);
      exp_t e;
      @(negedge clk);
      op_valid = vld; op_code = op; src_form = fm;
      reg1_val = ra; reg2_val = rb; imm_val = im;
      e = model(vld, op, fm, ra, rb, im, mfl, tag);
      mfl = e.fl;
      q.push_back(e);
   endtask

   task automatic check(bit ok, string tag, string what,
                        logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: 1 ns after the edge that loads the flags, inputs still held
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(result_we == e.we, e.tag, "we", 32'(result_we), 32'(e.we));
            if (e.we) check(result == e.res, e.tag, "result", result, e.res);
            check(flags == e.fl, e.tag, "flags", 32'(flags), 32'(e.fl));
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(flags == 4'b0, "R12", "reset flags", 32'(flags), 32'h0);
      // R1 signed overflow, then unsigned wrap to zero
      send(1, 0, 0, 32'h0000_0001, 32'h7fff_ffff, 16'h0, "R1");
      send(1, 0, 0, 32'h0000_0001, 32'hffff_ffff, 16'h0, "R1");
      // R4 short immediate -1 sign-extended on ADD
      send(1, 0, 1, 32'h0, 32'h0000_0010, 16'h001f, "R4");
      // R4 long immediate 0x8000 sign-extended on ADD
      send(1, 0, 2, 32'h0, 32'h0000_0000, 16'h8000, "R4");
      // R2 borrow and overflow
      send(1, 1, 0, 32'h0000_0001, 32'h0000_0000, 16'h0, "R2");
      send(1, 1, 0, 32'h0000_0001, 32'h8000_0000, 16'h0, "R2");
      send(1, 2, 0, 32'h0000_0009, 32'h0000_0003, 16'h0, "R2");
      // R3 equal compare, then less-than with short immediate
      send(1, 3, 0, 32'h1234_5678, 32'h1234_5678, 16'h0, "R3");
      send(1, 3, 1, 32'h0, 32'h0000_0002, 16'h0005, "R3");
      // R5 logic keeps CY (set by the compare above), clears OV
      send(1, 4, 2, 32'h0, 32'h8000_0000, 16'h8000, "R5");
      send(1, 6, 0, 32'h00ff_00ff, 32'h00ff_00ff, 16'h0, "R5");
      send(1, 7, 0, 32'h0000_0000, 32'h0, 16'h0, "R5");
      // R6 AND with long immediate: S cleared
      send(1, 5, 2, 32'h0, 32'hffff_ffff, 16'hffff, "R6");
      send(1, 5, 0, 32'h8000_0000, 32'hffff_ffff, 16'h0, "R10");
      // R7 shifts
      send(1, 8, 0, 32'h0000_0021, 32'h8000_0001, 16'h0, "R7");
      send(1, 8, 1, 32'h0, 32'h4000_0000, 16'h0002, "R7");
      send(1, 9, 1, 32'h0, 32'h0000_0006, 16'h0002, "R7");
      send(1, 10, 1, 32'h0, 32'h8000_0000, 16'h001f, "R7");
      // R8 zero shift clears CY
      send(1, 8, 0, 32'h0, 32'hffff_ffff, 16'h0, "R8");
      send(1, 10, 0, 32'h0000_0020, 32'h8000_0001, 16'h0, "R8");
      // R9 movhi, flags unchanged after a flag-setting op
      send(1, 1, 0, 32'h0000_0001, 32'h8000_0000, 16'h0, "R2");
      send(1, 11, 2, 32'h0, 32'h0000_1234, 16'hffff, "R9");
      // R11 idle and unused code hold flags
      send(0, 0, 0, 32'h1, 32'hffff_ffff, 16'h0, "R11");
      send(1, 13, 0, 32'h0, 32'h0, 16'h0, "R11");
      send(0, 0, 0, 32'h0, 32'h0, 16'h0, "R11");
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R11", "queue drained", 32'(q.size()), 32'h0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule